// File: doc/BRIEF.md
# Multi-Source General Purpose Timer

This block is an up-counting timer behind a small word-addressed register bus. Software picks one of three count sources and arms the timer. The sources are a peripheral tick, a low-frequency reference tick and a high-frequency oscillator tick, and each arrives as a one-cycle enable strobe in the single system clock domain. Software then reads the running count to measure elapsed time. Ticks from the oscillator first pass a small dedicated pre-divider that has its own gate bit. Every source then passes a common 12-bit prescaler before it reaches the counter.

The bus has a word index, a write strobe, a read strobe and 32-bit data in each direction. Reads are combinational: read data is valid in the same cycle as the read strobe and is zero when no read is strobed. Writing the self-clearing software reset bit zeroes all state at the same clock edge.

Top module: `mst_timer`

## Requirements
- R1: After the synchronous active-high `rst`, the control, prescaler, status and counter words all read as zero.
- R2: Word index 0 is control, index 1 is prescaler, index 2 is status and index 9 is counter. These are byte offsets 0x00, 0x04, 0x08 and 0x24. Status always reads zero and ignores writes. Indices 3 to 8 and 10 to 15 read zero. While `bus_rd` is low, `bus_rdata` is zero.
- R3: A control write with bit 15 set clears control, prescaler and counter at that edge. Bit 15 then reads back as 0, and a later write of zero leaves everything cleared.
- R4: Control bits 8:6 pick the source: 001 is the peripheral tick, 100 the low-frequency tick and 101 the oscillator tick. With both dividers at 0, each strobe of the selected source adds one to the counter, and strobes of the other sources are ignored.
- R5: Any other value of bits 8:6 selects nothing, and the counter holds.
- R6: Control bit 0 enables counting. While it is 0 the counter holds.
- R7: Control bit 10 gates the oscillator. With source 101 and bit 10 clear, the counter holds.
- R8: Prescaler bits 15:12 (N) let one oscillator-path tick through per N+1 oscillator strobes. This field has no effect on the other sources.
- R9: Prescaler bits 11:0 (M) let one count through per M+1 selected-source ticks. Used together with the oscillator, the counter advances once per (N+1)(M+1) strobes.
- R10: Control bit 9 is stored and read back, and it does not change counting.
- R11: The counter ignores writes. It reads zero-extended to 32 bits and wraps from all ones to zero.
- R12: A control write that changes bits 8:6, or any cycle with bit 0 clear, restarts both divider phases. The next count then needs a full M+1 (and N+1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| tick_per | input | 1 | Peripheral source tick strobe |
| tick_lf | input | 1 | Low-frequency reference tick strobe |
| tick_hf | input | 1 | High-frequency oscillator tick strobe |

## Verification
The bench builds the timer with `CNT_W = 8`. At the full 32-bit width, the wrap from all ones to zero would need billions of strobes. At 8 bits it is reached after a few hundred peripheral ticks, so the wrap and the zero-extended read of a narrow counter are both checked directly. Divider settings are kept small (N = 7, M up to 3) so that partial phases, the exact count on which a prescaled tick appears and the phase restart on a source or enable change all fall in a short run.

// File: rtl/mst_pkg.sv
package mst_pkg;

    localparam int BUS_W      = 32;
    localparam int IDX_W      = 4;
    localparam int HF_DIV_W   = 4;
    localparam int MAIN_DIV_W = 12;

    // word indices decoded by software drivers
    localparam logic [IDX_W-1:0] IDX_CTRL = 4'd0;
    localparam logic [IDX_W-1:0] IDX_PRE  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'd2;
    localparam logic [IDX_W-1:0] IDX_CNT  = 4'd9;

    // control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_SRC_LO = 6;
    localparam int CB_FRR    = 9;
    localparam int CB_HFEN   = 10;
    localparam int CB_SWR    = 15;
    // prescaler field position
    localparam int PB_HF_LO  = 12;

    typedef enum logic [2:0] {
        SRC_NONE = 3'b000,
        SRC_PER  = 3'b001,
        SRC_LF   = 3'b100,
        SRC_HF   = 3'b101
    } src_e;

    typedef struct packed {
        logic       hf_en;
        logic       frr;
        logic [2:0] src;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [HF_DIV_W-1:0]   hf_div;
        logic [MAIN_DIV_W-1:0] main_div;
    } pre_t;

    function automatic ctrl_t ctrl_from_word(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.en    = w[CB_EN];
        c.src   = w[CB_SRC_LO +: 3];
        c.frr   = w[CB_FRR];
        c.hf_en = w[CB_HFEN];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CB_EN]          = c.en;
        w[CB_SRC_LO +: 3] = c.src;
        w[CB_FRR]         = c.frr;
        w[CB_HFEN]        = c.hf_en;
        return w;
    endfunction

    function automatic pre_t pre_from_word(input logic [BUS_W-1:0] w);
        pre_t p;
        p.main_div = w[MAIN_DIV_W-1:0];
        p.hf_div   = w[PB_HF_LO +: HF_DIV_W];
        return p;
    endfunction

    function automatic logic [BUS_W-1:0] pre_to_word(input pre_t p);
        logic [BUS_W-1:0] w;
        w = '0;
        w[MAIN_DIV_W-1:0]        = p.main_div;
        w[PB_HF_LO +: HF_DIV_W]  = p.hf_div;
        return w;
    endfunction

endpackage

// File: rtl/mst_regs.sv
module mst_regs
    import mst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    output ctrl_t            ctrl_o,
    output pre_t             pre_o,
    output logic             soft_rst_o,
    output logic             src_chg_o
);
    ctrl_t ctrl_q;
    pre_t  pre_q;
    ctrl_t ctrl_new;
    logic  hit_ctrl;
    logic  hit_pre;
    logic  unused_wbits;

    assign hit_ctrl   = wr && (idx == IDX_CTRL);
    assign hit_pre    = wr && (idx == IDX_PRE);
    assign ctrl_new   = ctrl_from_word(wdata);
    assign soft_rst_o = hit_ctrl && wdata[CB_SWR];
    assign src_chg_o  = hit_ctrl && !wdata[CB_SWR] && (ctrl_new.src != ctrl_q.src);
    assign unused_wbits = ^{wdata[BUS_W-1:16], wdata[14:11], wdata[5:1]};

    always_ff @(posedge clk) begin
        if (rst || soft_rst_o) begin
            ctrl_q <= '0;
            pre_q  <= '0;
        end else begin
            if (hit_ctrl) ctrl_q <= ctrl_new;
            if (hit_pre)  pre_q  <= pre_from_word(wdata);
        end
    end

    assign ctrl_o = ctrl_q;
    assign pre_o  = pre_q;
endmodule

// File: rtl/mst_src_sel.sv
module mst_src_sel
    import mst_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  tick_per,
    input  logic  tick_lf,
    input  logic  tick_hf,
    input  logic  hf_div_tick,
    output logic  hf_raw_o,
    output logic  sel_tick_o
);
    always_comb begin
        hf_raw_o   = 1'b0;
        sel_tick_o = 1'b0;
        if (ctrl.en) begin
            case (ctrl.src)
                SRC_PER: sel_tick_o = tick_per;
                SRC_LF:  sel_tick_o = tick_lf;
                SRC_HF: begin
                    hf_raw_o   = tick_hf && ctrl.hf_en;
                    sel_tick_o = hf_div_tick;
                end
                default: sel_tick_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mst_div.sv
module mst_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] phase_q;
    logic         at_end;

    // >= keeps the divider sane when the divisor shrinks mid-phase
    assign at_end = (phase_q >= div_i);
    assign tick_o = tick_i && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/mst_timer.sv
module mst_timer
    import mst_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick_per,
    input  logic             tick_lf,
    input  logic             tick_hf
);
    ctrl_t            ctrl_q;
    pre_t             pre_q;
    logic             soft_rst;
    logic             src_chg;
    logic             div_clr;
    logic             hf_raw;
    logic             hf_div_tick;
    logic             sel_tick;
    logic             cnt_tick;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] rd_mux;

    mst_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (bus_wr),
        .idx        (bus_addr),
        .wdata      (bus_wdata),
        .ctrl_o     (ctrl_q),
        .pre_o      (pre_q),
        .soft_rst_o (soft_rst),
        .src_chg_o  (src_chg)
    );

    mst_src_sel u_sel (
        .ctrl        (ctrl_q),
        .tick_per    (tick_per),
        .tick_lf     (tick_lf),
        .tick_hf     (tick_hf),
        .hf_div_tick (hf_div_tick),
        .hf_raw_o    (hf_raw),
        .sel_tick_o  (sel_tick)
    );

    assign div_clr = src_chg || !ctrl_q.en;

    mst_div #(.W(HF_DIV_W)) u_hf_div (
        .clk    (clk),
        .rst    (rst || soft_rst),
        .clr    (div_clr),
        .tick_i (hf_raw),
        .div_i  (pre_q.hf_div),
        .tick_o (hf_div_tick)
    );

    mst_div #(.W(MAIN_DIV_W)) u_main_div (
        .clk    (clk),
        .rst    (rst || soft_rst),
        .clr    (div_clr),
        .tick_i (sel_tick),
        .div_i  (pre_q.main_div),
        .tick_o (cnt_tick)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cnt_q <= '0;
        end else if (cnt_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            IDX_CTRL: rd_mux = ctrl_to_word(ctrl_q);
            IDX_PRE:  rd_mux = pre_to_word(pre_q);
            IDX_STAT: rd_mux = '0;
            IDX_CNT:  rd_mux[CNT_W-1:0] = cnt_q;
            default:  rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/mst_timer_chk.sv
module mst_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             wbit_swr,
    input logic [31:0]      bus_rdata,
    input logic             en_q,
    input logic [2:0]       src_q,
    input logic             hfen_q,
    input logic [5:0]       ctrl_bits,
    input logic [15:0]      pre_bits,
    input logic [CNT_W-1:0] cnt_q
);
    logic swr_wr;
    logic src_ok;

    assign swr_wr = bus_wr && (bus_addr == 4'd0) && wbit_swr;
    assign src_ok = (src_q == 3'b001) || (src_q == 3'b100) || (src_q == 3'b101);

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 32'd0));

    p_swr_clears_r3: assert property (@(posedge clk) disable iff (rst)
        swr_wr |=> (cnt_q == '0 && ctrl_bits == '0 && pre_bits == '0));

    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        !swr_wr |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    p_bad_src_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!src_ok && !swr_wr) |=> $stable(cnt_q));

    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !swr_wr) |=> $stable(cnt_q));

    p_hf_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (src_q == 3'b101 && !hfen_q && !swr_wr) |=> $stable(cnt_q));
endmodule

bind mst_timer mst_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wbit_swr  (bus_wdata[15]),
    .bus_rdata (bus_rdata),
    .en_q      (ctrl_q.en),
    .src_q     (ctrl_q.src),
    .hfen_q    (ctrl_q.hf_en),
    .ctrl_bits (ctrl_q),
    .pre_bits  (pre_q),
    .cnt_q     (cnt_q)
);

// File: tb/mst_timer_tb.sv
module mst_timer_tb;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_per = 1'b0;
    logic        tick_lf = 1'b0;
    logic        tick_hf = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  idx;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t mon_item;

    always #10 clk = ~clk;

    mst_timer #(.CNT_W(CW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_per  (tick_per),
        .tick_lf   (tick_lf),
        .tick_hf   (tick_hf)
    );

    // monitor: pops one expected item per strobed read
    always @(negedge clk) begin
        if (bus_rd) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty: read idx %0d got %h expected nothing", bus_addr, bus_rdata);
            end else begin
                mon_item = sb.pop_front();
                if (bus_rdata !== mon_item.exp || bus_addr !== mon_item.idx) begin
                    bad++;
                    $display("FAIL %s idx %0d: actual %h expected %h",
                             mon_item.tag, mon_item.idx, bus_rdata, mon_item.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        bus_addr = idx; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_exp(input logic [3:0] idx, input logic [31:0] e, input string tag);
        exp_t it;
        it.idx = idx; it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_addr = idx; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // sel: 0 peripheral, 1 low-frequency, 2 oscillator, 3 all
    task automatic pulse(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            tick_per = (sel == 0) || (sel == 3);
            tick_lf  = (sel == 1) || (sel == 3);
            tick_hf  = (sel == 2) || (sel == 3);
            @(posedge clk); #1;
        end
        tick_per = 1'b0; tick_lf = 1'b0; tick_hf = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_exp(4'd0, 32'h0, "R1");
        rd_exp(4'd1, 32'h0, "R1");
        rd_exp(4'd2, 32'h0, "R1");
        rd_exp(4'd9, 32'h0, "R1");

        // R2 unused words and status ignore writes, idle read is zero
        for (int k = 3; k <= 8; k++) wr(4'(k), 32'hDEAD_BEEF);
        wr(4'd2, 32'hFFFF_FFFF);
        for (int k = 3; k <= 8; k++) rd_exp(4'(k), 32'h0, "R2");
        rd_exp(4'd2, 32'h0, "R2");
        bus_addr = 4'd0;
        wr(4'd0, 32'h0000_0500);
        bus_addr = 4'd0;
        @(negedge clk);
        total++;
        if (bus_rdata !== 32'h0) begin
            bad++;
            $display("FAIL R2 idle read: actual %h expected %h", bus_rdata, 32'h0);
        end
        @(posedge clk); #1;
        wr(4'd0, 32'h0);

        // R4 peripheral source
        wr(4'd0, 32'h0000_0041);
        pulse(0, 5);
        rd_exp(4'd9, 32'd5, "R4");
        pulse(1, 3);
        rd_exp(4'd9, 32'd5, "R4");

        // R6 enable cleared
        wr(4'd0, 32'h0000_0040);
        pulse(0, 4);
        rd_exp(4'd9, 32'd5, "R6");

        // R4 low-frequency source
        wr(4'd0, 32'h0000_0101);
        pulse(1, 3);
        rd_exp(4'd9, 32'd8, "R4");
        pulse(0, 2);
        rd_exp(4'd9, 32'd8, "R4");

        // R7 oscillator gate
        wr(4'd0, 32'h0000_0141);
        pulse(2, 4);
        rd_exp(4'd9, 32'd8, "R7");
        wr(4'd0, 32'h0000_0541);
        pulse(2, 2);
        rd_exp(4'd9, 32'd10, "R4");

        // R10 restart-mode bit stored, no effect
        wr(4'd0, 32'h0000_0741);
        rd_exp(4'd0, 32'h0000_0741, "R10");
        pulse(2, 1);
        rd_exp(4'd9, 32'd11, "R10");

        // R5 unassigned source codes
        wr(4'd0, 32'h0000_0001);
        pulse(3, 2);
        wr(4'd0, 32'h0000_0081);
        pulse(3, 2);
        wr(4'd0, 32'h0000_00C1);
        pulse(3, 2);
        wr(4'd0, 32'h0000_0181);
        pulse(3, 2);
        wr(4'd0, 32'h0000_05C1);
        pulse(3, 2);
        rd_exp(4'd9, 32'd11, "R5");

        // R8 oscillator pre-divider, N = 7
        wr(4'd1, 32'h0000_7000);
        rd_exp(4'd1, 32'h0000_7000, "R8");
        wr(4'd0, 32'h0000_0541);
        pulse(2, 16);
        rd_exp(4'd9, 32'd13, "R8");
        pulse(2, 7);
        rd_exp(4'd9, 32'd13, "R8");
        pulse(2, 1);
        rd_exp(4'd9, 32'd14, "R8");
        wr(4'd0, 32'h0000_0041);
        pulse(0, 3);
        rd_exp(4'd9, 32'd17, "R8");

        // R9 main prescaler, M = 2, then combined N = 1, M = 1
        wr(4'd1, 32'h0000_0002);
        pulse(0, 6);
        rd_exp(4'd9, 32'd19, "R9");
        pulse(0, 2);
        rd_exp(4'd9, 32'd19, "R9");
        pulse(0, 1);
        rd_exp(4'd9, 32'd20, "R9");
        wr(4'd1, 32'h0000_1001);
        wr(4'd0, 32'h0000_0541);
        pulse(2, 8);
        rd_exp(4'd9, 32'd22, "R9");

        // R12 phase restart on enable clear and on source change, M = 3
        wr(4'd1, 32'h0000_0003);
        wr(4'd0, 32'h0000_0041);
        pulse(0, 3);
        wr(4'd0, 32'h0000_0040);
        wr(4'd0, 32'h0000_0041);
        pulse(0, 3);
        rd_exp(4'd9, 32'd22, "R12");
        pulse(0, 1);
        rd_exp(4'd9, 32'd23, "R12");
        pulse(0, 2);
        wr(4'd0, 32'h0000_0101);
        pulse(1, 3);
        rd_exp(4'd9, 32'd23, "R12");
        pulse(1, 1);
        rd_exp(4'd9, 32'd24, "R12");

        // R11 read-only and wrap
        wr(4'd9, 32'h0000_0055);
        rd_exp(4'd9, 32'd24, "R11");
        wr(4'd1, 32'h0);
        wr(4'd0, 32'h0000_0041);
        pulse(0, 231);
        rd_exp(4'd9, 32'h0000_00FF, "R11");
        pulse(0, 1);
        rd_exp(4'd9, 32'h0, "R11");
        pulse(0, 1);
        rd_exp(4'd9, 32'd1, "R11");

        // R3 software reset
        wr(4'd1, 32'h0000_3005);
        wr(4'd0, 32'h0000_0741);
        wr(4'd0, 32'h0000_8000);
        rd_exp(4'd0, 32'h0, "R3");
        rd_exp(4'd1, 32'h0, "R3");
        rd_exp(4'd9, 32'h0, "R3");
        wr(4'd0, 32'h0);
        pulse(0, 2);
        rd_exp(4'd0, 32'h0, "R3");
        rd_exp(4'd9, 32'h0, "R3");

        repeat (2) @(posedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule